// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts cycles and selected hardware events for software profiling. It holds one free-running cycle counter and four programmable event counters, each 32 bits wide. Every event counter watches one line of a 256-wide event bus; an 8-bit type field picks the line. A word-addressed register port gives software access to the unit. The read path is combinational, and writes take effect at the clock edge.

Each counter has its own enable, interrupt enable and overflow flag. Enables are changed through write-one set and clear registers. Flags are cleared by writing ones back to them. The event counters are reached indirectly through a selector. For sampling, software loads a counter with the negated period. The counter overflows after exactly that many counts and raises the interrupt if that counter's interrupt is enabled.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter is 0, every register address 0 to 8 reads 0, and `irq` is low.
- R2: Control register (address 0), bit 0 is the global enable, which gates all counting. The cycle counter adds 1 at each clock edge where, before that edge, both the global enable and its own enable bit are set. With either bit clear, it holds its value.
- R3: In the enable masks, bits 0 to 3 belong to event counters 0 to 3 and bit 31 belongs to the cycle counter. Address 1 sets enables where a 1 is written, and address 2 clears them where a 1 is written. Bits written as 0 have no effect. Both addresses read back the current mask.
- R4: Event counter i adds 1 at an edge where the global enable and its own enable are set and `events[type_i]` is high.
- R5: The selector (address 5, bits 1:0) picks an event counter. The type window (address 7, bits 7:0) and the count window (address 8) read and write only the selected counter.
- R6: The cycle counter is read and written directly at address 6.
- R7: Writing 1 to control bit 1 zeroes all event counters. Writing 1 to control bit 2 zeroes the cycle counter. Neither bit is stored, and both read back as 0.
- R8: When a counter wraps from all-ones to zero, its flag is set at that same edge. A counter preloaded with -N therefore overflows on exactly the N-th increment.
- R9: The flag register (address 4, same bit layout as R3) returns the pending flags. Writing a 1 clears a flag, and writing a 0 leaves it unchanged. An overflow at the same edge as a clear of that flag leaves the flag set.
- R10: Address 3 sets interrupt enables where a 1 is written and reads back the mask. `irq` is high exactly when some flag and its interrupt enable are both set.
- R11: A software write to a counter at the same edge as an increment stores the written value. Counting continues from that value at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| events | input | 256 | Event lines watched by the event counters |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of actions can fall on the same edge: a software write to a count register while that counter is incrementing, and a flag-clear write while the same counter wraps. The bench provokes the first by writing the cycle counter and an event-counter window while they are running. It passes when the written value reads back right after the write and increases by one at the next edge. For the second, the bench preloads the cycle counter with all-ones and schedules the flag-clear write on the edge where the counter wraps. It passes when the flag and `irq` are still set afterward. Random event traffic and random enable masks are checked against counts kept by the bench.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    typedef enum logic [3:0] {
        ADR_CTRL   = 4'd0,
        ADR_ENSET  = 4'd1,
        ADR_ENCLR  = 4'd2,
        ADR_IESET  = 4'd3,
        ADR_FLAG   = 4'd4,
        ADR_SEL    = 4'd5,
        ADR_CYC    = 4'd6,
        ADR_EVTYPE = 4'd7,
        ADR_EVCNT  = 4'd8
    } pmu_addr_e;

    localparam int CTRL_GLOBAL_BIT = 0;
    localparam int CTRL_EVRST_BIT  = 1;
    localparam int CTRL_CYRST_BIT  = 2;
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel #(
    parameter int NUM_EVENTS = 256,
    parameter int TYPE_W     = 8
) (
    input  logic [NUM_EVENTS-1:0] events,
    input  logic [TYPE_W-1:0]     ev_type,
    output logic                  hit
);
    localparam int SPAN = 1 << TYPE_W;

    generate
        if (NUM_EVENTS >= SPAN) begin : g_full
            assign hit = events[ev_type];
        end else begin : g_partial
            always_comb begin
                hit = 1'b0;
                for (int k = 0; k < NUM_EVENTS; k++) begin
                    if (ev_type == TYPE_W'(k)) hit = events[k];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        ovf  = 1'b0;
        if (load) begin
            st_d.count = load_val;
        end else if (clr) begin
            st_d.count = '0;
        end else if (inc) begin
            st_d.count = st_q.count + W'(1);
            ovf        = &st_q.count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    AST_LOAD_WINS: // R11
    assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.count == $past(load_val)));

    AST_STEP_ONE: // R2
    assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && !clr) |=> (st_q.count == $past(st_q.count) + W'(1)));

    AST_CLEAR_ZERO: // R7
    assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> (st_q.count == '0));

    AST_IDLE_HOLD: // R2
    assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load && !clr) |=> $stable(st_q.count));
endmodule

// File: rtl/pmu_ctrl_regs.sv
module pmu_ctrl_regs
    import pmu_pkg::*;
#(
    parameter int NUM_EVT = 4,
    parameter int TYPE_W  = 8,
    parameter int DATA_W  = 32,
    localparam int NUM_CNT = NUM_EVT + 1,
    localparam int SEL_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [3:0]                     reg_addr,
    input  logic [NUM_CNT-1:0]             wmask,
    input  logic [TYPE_W-1:0]              wlow,
    input  logic [NUM_CNT-1:0]             ovf,
    output logic                           glob_en,
    output logic [NUM_CNT-1:0]             cnt_en,
    output logic [SEL_W-1:0]               sel,
    output logic [NUM_EVT-1:0][TYPE_W-1:0] ev_type,
    output logic                           evt_rst,
    output logic                           cyc_rst,
    output logic                           irq,
    output logic [DATA_W-1:0]              cfg_rdata
);
    localparam int CYC_BIT = DATA_W - 1;

    typedef struct packed {
        logic                           glob_en;
        logic [NUM_CNT-1:0]             en;
        logic [NUM_CNT-1:0]             ie;
        logic [NUM_CNT-1:0]             flag;
        logic [SEL_W-1:0]               sel;
        logic [NUM_EVT-1:0][TYPE_W-1:0] ev_type;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    function automatic logic [DATA_W-1:0] to_word(input logic [NUM_CNT-1:0] m);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int k = 0; k < NUM_EVT; k++) w[k] = m[k];
        w[CYC_BIT] = m[NUM_EVT];
        return w;
    endfunction

    always_comb begin
        st_d    = st_q;
        evt_rst = 1'b0;
        cyc_rst = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                ADR_CTRL: begin
                    st_d.glob_en = wlow[CTRL_GLOBAL_BIT];
                    evt_rst      = wlow[CTRL_EVRST_BIT];
                    cyc_rst      = wlow[CTRL_CYRST_BIT];
                end
                ADR_ENSET:  st_d.en   = st_q.en | wmask;
                ADR_ENCLR:  st_d.en   = st_q.en & ~wmask;
                ADR_IESET:  st_d.ie   = st_q.ie | wmask;
                ADR_FLAG:   st_d.flag = st_q.flag & ~wmask;
                ADR_SEL:    st_d.sel  = wlow[SEL_W-1:0];
                ADR_EVTYPE: st_d.ev_type[st_q.sel] = wlow;
                default: ;
            endcase
        end
        st_d.flag = st_d.flag | ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        case (reg_addr)
            ADR_CTRL:              cfg_rdata[CTRL_GLOBAL_BIT] = st_q.glob_en;
            ADR_ENSET, ADR_ENCLR:  cfg_rdata = to_word(st_q.en);
            ADR_IESET:             cfg_rdata = to_word(st_q.ie);
            ADR_FLAG:              cfg_rdata = to_word(st_q.flag);
            ADR_SEL:               cfg_rdata[SEL_W-1:0] = st_q.sel;
            ADR_EVTYPE:            cfg_rdata[TYPE_W-1:0] = st_q.ev_type[st_q.sel];
            default: ;
        endcase
    end

    assign glob_en = st_q.glob_en;
    assign cnt_en  = st_q.en;
    assign sel     = st_q.sel;
    assign ev_type = st_q.ev_type;
    assign irq     = |(st_q.flag & st_q.ie);

    AST_OVF_SETS_FLAG: // R8
    assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf) |=> ((st_q.flag & $past(ovf)) == $past(ovf)));

    AST_FLAG_STICKY: // R9
    assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADR_FLAG) |=> ((st_q.flag & $past(st_q.flag)) == $past(st_q.flag)));

    AST_ENSET_TAKES: // R3
    assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_ENSET) |=> ((st_q.en & $past(wmask)) == $past(wmask)));

    AST_ENCLR_TAKES: // R3
    assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_ENCLR) |=> ((st_q.en & $past(wmask)) == '0));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import pmu_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int NUM_EVT    = 4,
    parameter int TYPE_W     = 8,
    parameter int NUM_EVENTS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  reg_wr,
    input  logic [3:0]            reg_addr,
    input  logic [CNT_W-1:0]      reg_wdata,
    output logic [CNT_W-1:0]      reg_rdata,
    output logic                  irq
);
    localparam int NUM_CNT = NUM_EVT + 1;
    localparam int CYC_IDX = NUM_EVT;
    localparam int CYC_BIT = CNT_W - 1;
    localparam int SEL_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic                           glob_en;
    logic [NUM_CNT-1:0]             cnt_en;
    logic [SEL_W-1:0]               sel;
    logic [NUM_EVT-1:0][TYPE_W-1:0] ev_type;
    logic                           evt_rst;
    logic                           cyc_rst;
    logic [CNT_W-1:0]               cfg_rdata;
    logic [NUM_CNT-1:0]             wmask;
    logic [NUM_CNT-1:0]             ovf;
    logic [CNT_W-1:0]               cnt_val [NUM_CNT];
    logic                           wr_cyc;
    logic                           wr_evcnt;

    always_comb begin
        for (int k = 0; k < NUM_EVT; k++) wmask[k] = reg_wdata[k];
        wmask[CYC_IDX] = reg_wdata[CYC_BIT];
    end

    assign wr_cyc   = reg_wr && (reg_addr == ADR_CYC);
    assign wr_evcnt = reg_wr && (reg_addr == ADR_EVCNT);

    pmu_ctrl_regs #(
        .NUM_EVT (NUM_EVT),
        .TYPE_W  (TYPE_W),
        .DATA_W  (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .wmask     (wmask),
        .wlow      (reg_wdata[TYPE_W-1:0]),
        .ovf       (ovf),
        .glob_en   (glob_en),
        .cnt_en    (cnt_en),
        .sel       (sel),
        .ev_type   (ev_type),
        .evt_rst   (evt_rst),
        .cyc_rst   (cyc_rst),
        .irq       (irq),
        .cfg_rdata (cfg_rdata)
    );

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            logic inc_i;
            logic load_i;
            logic clr_i;
            if (i == CYC_IDX) begin : g_cycle
                assign inc_i  = glob_en & cnt_en[i];
                assign load_i = wr_cyc;
                assign clr_i  = cyc_rst;
            end else begin : g_event
                logic hit_i;
                pmu_event_sel #(
                    .NUM_EVENTS (NUM_EVENTS),
                    .TYPE_W     (TYPE_W)
                ) u_sel (
                    .events  (events),
                    .ev_type (ev_type[i]),
                    .hit     (hit_i)
                );
                assign inc_i  = glob_en & cnt_en[i] & hit_i;
                assign load_i = wr_evcnt && (sel == SEL_W'(i));
                assign clr_i  = evt_rst;
            end
            pmu_counter #(.W(CNT_W)) u_counter (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load_i),
                .load_val (reg_wdata),
                .clr      (clr_i),
                .inc      (inc_i),
                .count    (cnt_val[i]),
                .ovf      (ovf[i])
            );
        end
    endgenerate

    always_comb begin
        case (reg_addr)
            ADR_CYC:   reg_rdata = cnt_val[CYC_IDX];
            ADR_EVCNT: reg_rdata = cnt_val[sel];
            default:   reg_rdata = cfg_rdata;
        endcase
    end

    AST_FROZEN_WHEN_OFF: // R2
    assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !reg_wr) |=> $stable(cnt_val[CYC_IDX]));

    AST_NO_IRQ_UNFLAGGED: // R10
    assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && ovf == '0 && !(reg_wr && reg_addr == ADR_IESET)) |=> !irq);
endmodule

// File: tb/perf_mon_unit_tb_top.sv
module perf_mon_unit_tb_top;
    localparam time HALF = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [255:0] events = '0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #HALF clk = ~clk;

    perf_mon_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .events    (events),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    function automatic logic [31:0] neg(input logic [31:0] n);
        return ~n + 32'd1;
    endfunction

    initial begin
        logic [31:0] en_model;
        logic [31:0] exp_cnt [4];
        logic [7:0]  typ [4];
        logic [31:0] sm, cm;
        void'($urandom(32'd20240607));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 9; a++) rd_chk("R1 reset read", 4'(a), 32'h0);
        chk("R1 irq low", {31'd0, irq}, 32'h0);

        // R3 directed set/clear
        wr(4'd1, 32'h8000_0005);
        rd_chk("R3 enset read", 4'd1, 32'h8000_0005);
        rd_chk("R3 enclr read", 4'd2, 32'h8000_0005);
        wr(4'd2, 32'h0000_0001);
        rd_chk("R3 clear bit0", 4'd1, 32'h8000_0004);
        wr(4'd1, 32'h0);
        rd_chk("R3 zero write no effect", 4'd1, 32'h8000_0004);
        // R3 random masks
        en_model = 32'h8000_0004;
        for (int k = 0; k < 20; k++) begin
            sm = $urandom();
            cm = $urandom();
            wr(4'd1, sm);
            wr(4'd2, cm);
            en_model = (en_model | (sm & 32'h8000_000F)) & ~(cm & 32'h8000_000F);
            rd_chk("R3 random mask", 4'd1, en_model);
        end
        wr(4'd2, 32'hFFFF_FFFF);
        rd_chk("R3 all cleared", 4'd2, 32'h0);

        // R6 direct cycle count, R2 gating
        wr(4'd6, 32'd100);
        rd_chk("R6 cycle write", 4'd6, 32'd100);
        wr(4'd1, 32'h8000_0000);
        repeat (5) @(negedge clk);
        rd_chk("R2 no count without global", 4'd6, 32'd100);
        wr(4'd0, 32'h1);
        rd_chk("R2 ctrl readback", 4'd0, 32'h1);
        repeat (10) @(negedge clk);
        rd_chk("R2 cycle counts", 4'd6, 32'd110);
        wr(4'd0, 32'h0);
        repeat (3) @(negedge clk);
        rd_chk("R2 counting stops", 4'd6, 32'd111);

        // R7 counter resets
        wr(4'd0, 32'h4);
        rd_chk("R7 cycle reset", 4'd6, 32'd0);
        rd_chk("R7 reset bits read 0", 4'd0, 32'h0);
        wr(4'd6, 32'd123);
        wr(4'd5, 32'd2); wr(4'd8, 32'd77);
        wr(4'd5, 32'd1); wr(4'd8, 32'd55);
        wr(4'd0, 32'h2);
        rd_chk("R7 event reset sel1", 4'd8, 32'd0);
        wr(4'd5, 32'd2);
        rd_chk("R7 event reset sel2", 4'd8, 32'd0);
        rd_chk("R7 cycle untouched", 4'd6, 32'd123);
        rd_chk("R7 reset bits read 0 again", 4'd0, 32'h0);

        // R5 indirect windows
        for (int i = 0; i < 4; i++) begin
            wr(4'd5, 32'(i));
            wr(4'd7, 32'(8'h11 * (i + 1)));
            wr(4'd8, 32'(1000 + i));
        end
        for (int i = 0; i < 4; i++) begin
            wr(4'd5, 32'(i));
            rd_chk("R5 type window", 4'd7, 32'(8'h11 * (i + 1)));
            rd_chk("R5 count window", 4'd8, 32'(1000 + i));
        end
        rd_chk("R5 select readback", 4'd5, 32'd3);

        // R4 random event traffic
        wr(4'd0, 32'h2);
        for (int i = 0; i < 4; i++) begin
            typ[i] = 8'($urandom());
            exp_cnt[i] = 32'd0;
            wr(4'd5, 32'(i));
            wr(4'd7, {24'd0, typ[i]});
        end
        wr(4'd1, 32'h0000_000F);
        wr(4'd0, 32'h1);
        for (int c = 0; c < 300; c++) begin
            for (int w = 0; w < 8; w++) events[w*32 +: 32] = $urandom();
            for (int i = 0; i < 4; i++) if (events[typ[i]]) exp_cnt[i]++;
            @(negedge clk);
        end
        events = '0;
        wr(4'd0, 32'h0);
        for (int i = 0; i < 4; i++) begin
            wr(4'd5, 32'(i));
            rd_chk("R4 event count", 4'd8, exp_cnt[i]);
        end

        // R8 preload with negated period, R10 interrupt
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'h8000_0000);
        wr(4'd6, neg(32'd5));
        wr(4'd3, 32'h8000_0000);
        rd_chk("R10 ie readback", 4'd3, 32'h8000_0000);
        wr(4'd0, 32'h1);
        repeat (4) @(negedge clk);
        rd_chk("R8 one before wrap", 4'd6, 32'hFFFF_FFFF);
        rd_chk("R8 no flag yet", 4'd4, 32'h0);
        chk("R10 irq low before", {31'd0, irq}, 32'h0);
        @(negedge clk);
        rd_chk("R8 wrapped", 4'd6, 32'h0);
        rd_chk("R8 flag set", 4'd4, 32'h8000_0000);
        chk("R10 irq high", {31'd0, irq}, 32'h1);
        wr(4'd0, 32'h0);
        wr(4'd4, 32'h0);
        rd_chk("R9 zero write keeps flag", 4'd4, 32'h8000_0000);
        wr(4'd4, 32'h8000_0000);
        rd_chk("R9 flag cleared", 4'd4, 32'h0);
        chk("R10 irq drops", {31'd0, irq}, 32'h0);

        // R8 event counter overflow, R10 masked then enabled
        wr(4'd2, 32'h8000_0000);
        wr(4'd5, 32'd1);
        wr(4'd7, 32'd5);
        wr(4'd8, neg(32'd3));
        wr(4'd1, 32'h2);
        wr(4'd0, 32'h1);
        events[5] = 1'b1;
        repeat (3) @(negedge clk);
        events = '0;
        rd_chk("R8 event flag", 4'd4, 32'h2);
        chk("R10 irq masked", {31'd0, irq}, 32'h0);
        wr(4'd3, 32'h2);
        chk("R10 irq after ie set", {31'd0, irq}, 32'h1);
        wr(4'd4, 32'h2);
        chk("R10 irq after clear", {31'd0, irq}, 32'h0);

        // R9 clear and overflow on the same edge
        wr(4'd0, 32'h0);
        wr(4'd2, 32'h2);
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd1, 32'h8000_0000);
        wr(4'd0, 32'h1);
        wr(4'd4, 32'h8000_0000);
        rd_chk("R9 overflow beats clear", 4'd4, 32'h8000_0000);
        chk("R9 irq stays", {31'd0, irq}, 32'h1);

        // R11 write while counting
        wr(4'd6, 32'd500);
        rd_chk("R11 cycle write wins", 4'd6, 32'd500);
        @(negedge clk);
        rd_chk("R11 cycle resumes", 4'd6, 32'd501);
        wr(4'd5, 32'd1);
        wr(4'd1, 32'h2);
        events[5] = 1'b1;
        @(negedge clk);
        wr(4'd8, 32'd9);
        rd_chk("R11 event write wins", 4'd8, 32'd9);
        @(negedge clk);
        rd_chk("R11 event resumes", 4'd8, 32'd10);
        events = '0;
        wr(4'd0, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule